// File: doc/BRIEF.md
# Write-Masked Soft Reset Register Bank

This block is a small bank of memory-mapped registers whose stored bits drive a flattened vector of software-controlled reset lines. A stored 1 holds the matching output asserted (active high). Software reaches the bank over a simple register bus with a byte address, write data, a write strobe, a read strobe and registered read data. Registers sit at byte offsets 0, 4, 8 and so on.

A compile-time parameter picks one of two ways of laying bits into the 32-bit words. In masked mode, each word carries 16 reset bits. The upper half of every write is a per-bit enable for the lower half, so a single write can raise or drop one reset line without first reading the register back. In plain mode, each word carries 32 reset bits and a write overwrites the whole register. In plain mode, changing one line therefore takes a read, a modify and a write.

Reset line i lives in register i / P at bit i % P, where P is 16 in masked mode and 32 in plain mode. The bank drives NUM_REGS × P outputs in total.

Top module: `soft_reset_bank`

## Requirements
- R1: While `rst_n` is low, every stored bit clears to 0 at the clock edge, so all of `rst_out` and `bus_rdata` read 0 after that edge.
- R2: In masked mode, a write to an in-range register sets stored bit n (0..15) to `bus_wdata[n]` whenever `bus_wdata[n+16]` is 1. Bits 16+n and n both set asserts line n. Bit 16+n alone deasserts it.
- R3: In masked mode, a stored bit n whose enable `bus_wdata[n+16]` is 0 keeps its value, whatever `bus_wdata[n]` holds.
- R4: In masked mode, a read returns the 16 stored bits in `bus_rdata[15:0]` and zeros in `bus_rdata[31:16]`.
- R5: In plain mode, a write replaces all 32 stored bits of the addressed register with `bus_wdata`, and a read returns all 32.
- R6: Register k is addressed by `bus_addr[ADDR_W-1:2] == k` (`bus_addr[1:0]` is ignored). Its bit b drives `rst_out[k*P + b]`.
- R7: A write whose register index is NUM_REGS or more changes no output. A read at such an index returns 0.
- R8: A write updates `rst_out` at the clock edge where `bus_wr` is sampled high. `bus_rdata` is registered: after an edge with `bus_rd` high it holds the addressed register's value from before that edge's write. After an edge with `bus_rd` low it is 0.
- R9: On an edge with `bus_wr` low, no stored bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset of the bank |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_wdata | input | 32 | Write data (upper half is the bit enable in masked mode) |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data |
| rst_out | output | NUM_REGS*P | Flattened active-high reset lines |

## Verification
The hardest case to reach is a masked write where the enable and data halves disagree bit by bit. Examples are data bits set under a clear enable, or an enable with a zero data bit on a line that is already asserted. Only these writes show that unenabled bits really hold and that enabled bits clear. The directed stimulus builds known patterns first and then sends such conflicting words. A long run of random words over addresses both inside and beyond the bank follows, with reads and writes often in the same cycle. A behavioural model compares every cycle against one instance of each mode.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    function automatic int bits_per_reg(input bit masked);
        return masked ? HALF_W : WORD_W;
    endfunction
endpackage

// File: rtl/srb_decode.sv
module srb_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int FULL_W = ADDR_W - 2;
    localparam logic [FULL_W-1:0] LIMIT = FULL_W'(NUM_REGS);

    logic [FULL_W-1:0] word_idx;
    logic [1:0]        unused_lsb;

    always_comb begin
        word_idx   = addr[ADDR_W-1:2];
        unused_lsb = addr[1:0];
        hit        = (word_idx < LIMIT);
        idx        = word_idx[IDX_W-1:0];
    end
endmodule

// File: rtl/srb_word.sv
module srb_word
    import srb_pkg::*;
#(
    parameter bit MASKED = 1'b1,
    parameter int PER    = bits_per_reg(MASKED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [PER-1:0]    bits
);
    typedef struct packed {
        logic [PER-1:0] val;
    } word_s;

    word_s s_d, s_q;

    generate
        if (MASKED) begin : g_masked
            logic [PER-1:0] en;
            always_comb begin
                en = wdata[WORD_W-1:HALF_W];
                s_d = s_q;
                if (we) begin
                    s_d.val = (s_q.val & ~en) | (wdata[PER-1:0] & en);
                end
            end

            p_masked_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> ((s_q.val & $past(wdata[WORD_W-1:HALF_W])) ==
                        ($past(wdata[PER-1:0]) & $past(wdata[WORD_W-1:HALF_W]))));

            p_unmasked_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (((s_q.val ^ $past(s_q.val)) & ~$past(wdata[WORD_W-1:HALF_W])) == '0));
        end else begin : g_plain
            always_comb begin
                s_d = s_q;
                if (we) begin
                    s_d.val = wdata[PER-1:0];
                end
            end

            p_plain_replace_r5: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> (s_q.val == $past(wdata[PER-1:0])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bits = s_q.val;

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(s_q.val));
endmodule

// File: rtl/srb_readmux.sv
module srb_readmux
    import srb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int PER      = 16,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_REGS*PER-1:0] flat,
    input  logic                    hit,
    input  logic [IDX_W-1:0]        idx,
    output logic [WORD_W-1:0]       word
);
    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit && (idx == IDX_W'(k))) begin
                word[PER-1:0] = flat[k*PER +: PER];
            end
        end
    end
endmodule

// File: rtl/soft_reset_bank.sv
module soft_reset_bank
    import srb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    parameter bit MASKED   = 1'b1,
    parameter int PER      = bits_per_reg(MASKED),
    parameter int NUM_OUT  = NUM_REGS * PER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NUM_OUT-1:0] rst_out
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_s;

    rd_s r_d, r_q;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] mux_word;

    srb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            logic we_k;
            assign we_k = bus_wr && hit && (idx == IDX_W'(k));
            srb_word #(
                .MASKED (MASKED),
                .PER    (PER)
            ) u_word (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_k),
                .wdata (bus_wdata),
                .bits  (rst_out[k*PER +: PER])
            );
        end
    endgenerate

    srb_readmux #(
        .NUM_REGS (NUM_REGS),
        .PER      (PER),
        .IDX_W    (IDX_W)
    ) u_readmux (
        .flat (rst_out),
        .hit  (hit),
        .idx  (idx),
        .word (mux_word)
    );

    always_comb begin
        r_d = r_q;
        r_d.rdata = bus_rd ? mux_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;

    p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == '0));

    p_oob_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit && $past(rst_n)) |=> $stable(rst_out));

    p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    generate
        if (MASKED) begin : g_upper_chk
            p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (bus_rdata[WORD_W-1:HALF_W] == '0));
        end
    endgenerate
endmodule

// File: tb/tb_soft_reset_bank.sv
`timescale 1ns/1ps
module tb_soft_reset_bank;
    localparam int AW    = 8;
    localparam int NREGS = 4;
    localparam int NM    = NREGS * 16;
    localparam int NP    = NREGS * 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    rdata_m, rdata_p;
    logic [NM-1:0]  out_m;
    logic [NP-1:0]  out_p;

    logic [31:0] mm [NREGS];
    logic [31:0] mp [NREGS];
    logic [31:0] exp_rm, exp_rp;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    soft_reset_bank #(.ADDR_W(AW), .NUM_REGS(NREGS), .MASKED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_m), .rst_out(out_m));

    soft_reset_bank #(.ADDR_W(AW), .NUM_REGS(NREGS), .MASKED(1'b0)) dut_plain (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_p), .rst_out(out_p));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NM-1:0] flat_m();
        logic [NM-1:0] v;
        for (int k = 0; k < NREGS; k++) v[k*16 +: 16] = mm[k][15:0];
        return v;
    endfunction

    function automatic logic [NP-1:0] flat_p();
        logic [NP-1:0] v;
        for (int k = 0; k < NREGS; k++) v[k*32 +: 32] = mp[k];
        return v;
    endfunction

    task automatic compare(input string tag);
        chk({tag, " masked rst_out"}, 128'(out_m), 128'(flat_m()));
        chk({tag, " masked rdata"}, 128'(rdata_m), 128'(exp_rm));
        chk({"R5/", tag, " plain rst_out"}, 128'(out_p), 128'(flat_p()));
        chk({"R5/", tag, " plain rdata"}, 128'(rdata_p), 128'(exp_rp));
    endtask

    // One bus cycle: drive after an edge, update the model, sample 1 ns after the next edge
    task automatic step(input logic [AW-1:0] a, input logic [31:0] d,
                        input bit w, input bit r, input string tag);
        int idx;
        bit inr;
        logic [15:0] en;
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
        idx = int'(a >> 2);
        inr = (idx < NREGS);
        en  = d[31:16];
        exp_rm = (r && inr) ? {16'h0, mm[idx][15:0]} : 32'h0;   // R4, R8: pre-write value
        exp_rp = (r && inr) ? mp[idx] : 32'h0;
        if (w && inr) begin
            mm[idx] = {16'h0, (mm[idx][15:0] & ~en) | (d[15:0] & en)};
            mp[idx] = d;
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0;
        for (int k = 0; k < NREGS; k++) begin mm[k] = '0; mp[k] = '0; end
        exp_rm = '0; exp_rp = '0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            compare("R1");
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset(3);
        step(8'h00, 32'h0, 0, 1, "R1");
        // R2: assert line 3 of reg 0
        step(8'h00, 32'h0008_0008, 1, 0, "R2");
        step(8'h00, 32'h0, 0, 1, "R2");
        // R3: data bits without enables are ignored, only bit 4 enabled
        step(8'h00, 32'h0010_FFFF, 1, 1, "R3");
        step(8'h00, 32'h0, 0, 1, "R3");
        // R3: all enables zero, data all ones
        step(8'h00, 32'h0000_FFFF, 1, 0, "R3");
        // R2: deassert line 3 (enable only)
        step(8'h00, 32'h0008_0000, 1, 0, "R2");
        step(8'h00, 32'h0, 0, 1, "R2");
        // R6: reg 2 via address with nonzero low bits; line 2*16+5 in masked
        step(8'h0B, 32'hFFFF_A5A5, 1, 0, "R6");
        step(8'h08, 32'h0, 0, 1, "R6");
        step(8'h0C, 32'h8001_8001, 1, 1, "R6");
        // R4: readback of reg 3 upper half zero
        step(8'h0C, 32'h0, 0, 1, "R4");
        // R7: out-of-range writes and reads
        step(8'h10, 32'hFFFF_FFFF, 1, 1, "R7");
        step(8'hFC, 32'hFFFF_FFFF, 1, 1, "R7");
        step(8'h14, 32'h0, 0, 1, "R7");
        // R8: read and write same cycle returns old value, then new
        step(8'h04, 32'hFFFF_1234, 1, 1, "R8");
        step(8'h04, 32'h0, 0, 1, "R8");
        step(8'h04, 32'h0, 0, 0, "R8");
        // R9: idle cycles with data on the bus
        for (int i = 0; i < 4; i++) step(8'h04, 32'hFFFF_FFFF, 0, 0, "R9");
        // R1: reset in the middle of a run
        do_reset(1);
        step(8'h04, 32'h0, 0, 1, "R1");
        // random mixture over in-range and out-of-range addresses
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step({3'b000, rv[4:0]}, $urandom, rv[5], rv[6], "R2");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule